// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives asynchronous serial characters from a single line that rests high. It runs from the system clock and takes a one-cycle enable pulse at sixteen times the bit rate. The receiver waits for the line to go low, checks half a bit later that the low was a genuine start bit and not a glitch, and then samples each data bit at its centre. The character length is set to 5, 6, 7 or 8 bits. An even or odd parity bit can follow the data. One stop bit is checked.

Each finished character goes into a one-entry holding register. The register offers the character on a valid/ready pair, together with flags for parity error, framing error and overrun. A character whose data, parity and stop samples are all low counts as a line break and is not delivered. Instead, the block gives a one-cycle pulse when the break is recognised and a second pulse when the line returns high. After a framing error, the hunt for the next start bit is held off for half a bit, so that the low stop bit is not taken for a new start.

Top module: `rxu_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid`, `brk_start` and `brk_end` are 0.
- R2: A low that is detected but is high again at the 8th tick after detection is discarded: no character and no break event follow.
- R3: Data bit k (LSB first, k = 0..n-1) is sampled at tick 8+16(k+1) after the start detection. The length n is `cfg_len`+5 (00=5 ... 11=8). Unused upper bits of `out_data` read 0. The character is presented on the cycle after its stop sample.
- R4: With `cfg_par_en`=1, a parity bit follows the data. `out_perr` is 1 when the XOR of the data and parity bits is 1 with `cfg_par_odd`=0 (even), or is 0 with `cfg_par_odd`=1 (odd). With `cfg_par_en`=0, `out_perr` is 0.
- R5: A low stop sample on a character that is not a break sets `out_ferr`. The next start search then begins 8 ticks after that stop sample instead of on the following tick.
- R6: If a character completes while the held character is valid and not being accepted, the new character replaces it with `out_ovr`=1. Otherwise `out_ovr`=0.
- R7: When data, parity (if enabled) and stop samples are all low, no character is delivered and `brk_start` pulses for one cycle. `brk_end` pulses once on the cycle after the first tick that sees the line high again.
- R8: While `out_valid`=1 and `out_ready`=0, the held character and its flags stay unchanged until a new character arrives.
- R9: The line passes through a two-flop synchroniser that resets to the idle (high) level. All timing above counts from the synchronised line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Enable pulse at 16x the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Character length code, n = value+5 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| out_ready | input | 1 | Consumer accepts the held character |
| out_valid | output | 1 | Held character is valid |
| out_data | output | 8 | Received data, LSB is the first bit on the line |
| out_perr | output | 1 | Parity error flag of the held character |
| out_ferr | output | 1 | Framing error flag of the held character |
| out_ovr | output | 1 | Held character overwrote an unaccepted one |
| brk_start | output | 1 | One-cycle pulse when a break is recognised |
| brk_end | output | 1 | One-cycle pulse when the break ends |

## Verification
A line change reaches the receiver's decisions two clocks later, through the synchroniser. A character, or a break-start pulse, appears one clock after the tick that takes the stop sample. Data bits are taken 24, 40, ... ticks after the falling edge is detected, and a spike is resolved at tick 8. The bench keeps its own model, which ages the line by two clocks and counts ticks from detection. The model updates on the rising edge exactly as these latencies state, and the outputs are compared with it at every falling edge. The bench also makes scenario checks on accepted-character and break-pulse counts, and on the holding behaviour while `out_ready` is low.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

    localparam int CHAR_W   = 8;
    localparam int LEN_W    = 2;
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BRK,
        S_FDLY
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              ovr;
    } rx_char_t;

    function automatic logic [3:0] char_bits(input logic [LEN_W-1:0] code);
        return 4'(code) + 4'(MIN_BITS);
    endfunction

    function automatic logic parity_bad(input logic [CHAR_W-1:0] d,
                                        input logic pbit,
                                        input logic odd);
        return (^d) ^ pbit ^ odd;
    endfunction

endpackage

// File: rtl/rxu_sync.sv
module rxu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/rxu_core.sv
module rxu_core
    import rxu_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rxs,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    output logic             push,
    output rx_char_t         pchar,
    output logic             brk_start,
    output logic             brk_end
);
    localparam int CW   = $clog2(OSR);
    localparam int HALF = OSR / 2;
    localparam int IW   = $clog2(CHAR_W);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     bidx;
    logic [CHAR_W-1:0] shreg;
    logic              pbit;
    logic [3:0]        nbits;
    logic              bit_pt;
    logic              half_pt;
    logic              all_low;

    always_comb begin
        nbits   = char_bits(cfg_len);
        bit_pt  = tick && (cnt == CW'(OSR - 1));
        half_pt = tick && (cnt == CW'(HALF - 1));
        all_low = (shreg == '0) && !(cfg_par_en && pbit) && !rxs;
        push    = (state == S_STOP) && bit_pt && !all_low;
        pchar.data = shreg;
        pchar.perr = cfg_par_en && parity_bad(shreg, pbit, cfg_par_odd);
        pchar.ferr = !rxs;
        pchar.ovr  = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cnt       <= '0;
            bidx      <= '0;
            shreg     <= '0;
            pbit      <= 1'b0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
        end else begin
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
            if (tick) begin
                case (state)
                    S_IDLE: begin
                        if (!rxs) begin
                            state <= S_START;
                            cnt   <= '0;
                        end
                    end
                    S_START: begin
                        if (half_pt) begin
                            cnt <= '0;
                            if (!rxs) begin
                                state <= S_DATA;
                                bidx  <= '0;
                                shreg <= '0;
                                pbit  <= 1'b0;
                            end else begin
                                state <= S_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (bit_pt) begin
                            cnt         <= '0;
                            shreg[bidx] <= rxs;
                            if (bidx == IW'(nbits - 4'd1))
                                state <= cfg_par_en ? S_PAR : S_STOP;
                            else
                                bidx <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (bit_pt) begin
                            cnt   <= '0;
                            pbit  <= rxs;
                            state <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (bit_pt) begin
                            cnt <= '0;
                            if (all_low) begin
                                brk_start <= 1'b1;
                                state     <= S_BRK;
                            end else if (!rxs) begin
                                state <= S_FDLY;
                            end else begin
                                state <= S_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_BRK: begin
                        if (rxs) begin
                            brk_end <= 1'b1;
                            state   <= S_IDLE;
                        end
                    end
                    S_FDLY: begin
                        if (half_pt) state <= S_IDLE;
                        else         cnt   <= cnt + 1'b1;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R2: a start low that has gone high at the half-bit check leads back to idle
    assert_spike_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_START && half_pt && rxs) |=> (state == S_IDLE && !push));

    // R5: a framing error always enters the half-bit hold-off
    assert_ferr_delay_R5: assert property (@(posedge clk) disable iff (rst)
        (push && pchar.ferr) |=> (state == S_FDLY));

    // R7: nothing is delivered while a break lasts
    assert_brk_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_BRK) |-> !push);

    // R7: start and end pulses never coincide, and each lasts one cycle
    assert_brk_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        brk_start |-> (!brk_end ##1 !brk_start));

endmodule

// File: rtl/rxu_outbuf.sv
module rxu_outbuf
    import rxu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  rx_char_t in_char,
    input  logic     ready,
    output logic     valid,
    output rx_char_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            held  <= '0;
        end else if (push) begin
            valid    <= 1'b1;
            held     <= in_char;
            held.ovr <= valid && !ready;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    // R8: an unaccepted character is held unchanged
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready && !push) |=> (valid && $stable(held)));

    // R6: overwrite of an unaccepted character is flagged
    assert_overrun_R6: assert property (@(posedge clk) disable iff (rst)
        (push && valid && !ready) |=> (valid && held.ovr));

    // R6: a clean arrival carries no overrun flag
    assert_no_overrun_R6: assert property (@(posedge clk) disable iff (rst)
        (push && !(valid && !ready)) |=> !held.ovr);

endmodule

// File: rtl/rxu_top.sv
module rxu_top
    import rxu_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rx_in,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_data,
    output logic              out_perr,
    output logic              out_ferr,
    output logic              out_ovr,
    output logic              brk_start,
    output logic              brk_end
);
    logic     rxs;
    logic     push;
    rx_char_t pchar;
    rx_char_t held;

    rxu_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .dout (rxs)
    );

    rxu_core #(.OSR(OSR)) u_core (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .rxs         (rxs),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .push        (push),
        .pchar       (pchar),
        .brk_start   (brk_start),
        .brk_end     (brk_end)
    );

    rxu_outbuf u_obuf (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .in_char (pchar),
        .ready   (out_ready),
        .valid   (out_valid),
        .held    (held)
    );

    assign out_data = held.data;
    assign out_perr = held.perr;
    assign out_ferr = held.ferr;
    assign out_ovr  = held.ovr;

    // R1: outputs are quiet on the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !brk_start && !brk_end));

endmodule

// File: tb/tb_rxu_top.sv
module tb_rxu_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       out_ready = 1'b1;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_perr, out_ferr, out_ovr, brk_start, brk_end;

    always #2.5 clk = ~clk;

    rxu_top dut (
        .clk(clk), .rst(rst), .tick(tick), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_perr(out_perr), .out_ferr(out_ferr), .out_ovr(out_ovr),
        .brk_start(brk_start), .brk_end(brk_end)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int n_acc = 0;
    int n_bs  = 0;
    int n_be  = 0;
    bit done  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: line aged two clocks, ticks counted from detection
    logic       h1, h2, ls;
    int         m_mode, m_t, m_dly, m_n;
    bit         m_p;
    logic [7:0] m_sh;
    logic       m_pb;
    logic       m_push;
    logic [7:0] m_pd;
    logic       m_pp, m_pf;
    logic       mv, mperr, mferr, movr, ebs, ebe;
    logic [7:0] md;
    int         st_t;

    always @(posedge clk) begin
        if (rst) begin
            h1 = 1; h2 = 1;
            m_mode = 0; m_t = 0; m_dly = 0;
            mv = 0; md = 0; mperr = 0; mferr = 0; movr = 0; ebs = 0; ebe = 0;
            m_sh = 0; m_pb = 0;
        end else begin
            ls = h2; h2 = h1; h1 = rx_in;
            m_push = 0; ebs = 0; ebe = 0;
            if (tick) begin
                if (m_mode == 0) begin
                    if (!ls) begin m_mode = 1; m_t = 0; end
                end else if (m_mode == 1) begin
                    m_t++;
                    m_n = int'(cfg_len) + 5;
                    m_p = cfg_par_en;
                    st_t = 8 + 16 * (m_n + 1 + (m_p ? 1 : 0));
                    if (m_t == 8) begin
                        if (ls) m_mode = 0;
                        else begin m_sh = 0; m_pb = 0; end
                    end
                    for (int k = 0; k < m_n; k++)
                        if (m_t == 8 + 16 * (k + 1)) m_sh[k] = ls;
                    if (m_p && m_t == 8 + 16 * (m_n + 1)) m_pb = ls;
                    if (m_mode == 1 && m_t == st_t) begin
                        if (m_sh == 0 && !(m_p && m_pb) && !ls) begin
                            ebs = 1; m_mode = 2;
                        end else begin
                            m_push = 1; m_pd = m_sh;
                            m_pp = m_p && ((^m_sh) ^ m_pb ^ cfg_par_odd);
                            m_pf = !ls;
                            if (ls) m_mode = 0;
                            else begin m_mode = 3; m_dly = 0; end
                        end
                    end
                end else if (m_mode == 2) begin
                    if (ls) begin ebe = 1; m_mode = 0; end
                end else begin
                    m_dly++;
                    if (m_dly == 8) m_mode = 0;
                end
            end
            if (m_push) begin
                movr = mv && !out_ready;
                mv = 1; md = m_pd; mperr = m_pp; mferr = m_pf;
            end else if (mv && out_ready) begin
                mv = 0;
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(out_valid == mv, "R3 out_valid", out_valid, mv);
            if (mv) begin
                chk(out_data == md, "R3 out_data", out_data, md);
                chk(out_perr == mperr, "R4 out_perr", out_perr, mperr);
                chk(out_ferr == mferr, "R5 out_ferr", out_ferr, mferr);
                chk(out_ovr == movr, "R6 out_ovr", out_ovr, movr);
            end
            chk(brk_start == ebs, "R7 brk_start", brk_start, ebs);
            chk(brk_end == ebe, "R7 brk_end", brk_end, ebe);
            if (out_valid && out_ready) n_acc++;
            if (brk_start) n_bs++;
            if (brk_end) n_be++;
        end
    end

    task automatic put_bit(input logic b);
        rx_in = b;
        repeat (16) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int n, input bit pen, input bit podd,
                        input bit flip_par, input logic stopv, input int gap);
        logic pb;
        put_bit(1'b0);
        for (int i = 0; i < n; i++) put_bit(d[i]);
        if (pen) begin
            pb = 1'b0;
            for (int i = 0; i < n; i++) pb ^= d[i];
            pb = pb ^ podd ^ flip_par;
            put_bit(pb);
        end
        put_bit(stopv);
        rx_in = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        int a0, b0;
        logic [7:0] hold_d;
        repeat (3) @(negedge clk);
        chk(!out_valid && !brk_start && !brk_end, "R1 reset outputs", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !brk_start && !brk_end, "R1 after reset", out_valid, 0);
        repeat (10) @(negedge clk);

        // R3 / R9: 8-bit characters, no parity
        send(8'hA5, 8, 0, 0, 0, 1, 40);
        send(8'h3C, 8, 0, 0, 0, 1, 40);
        chk(n_acc == 2, "R3 two characters", n_acc, 2);

        // R2: short glitch
        a0 = n_acc;
        rx_in = 1'b0; repeat (4) @(negedge clk);
        rx_in = 1'b1; repeat (40) @(negedge clk);
        chk(n_acc == a0 && n_bs == 0, "R2 spike ignored", n_acc, a0);

        // R3 / R4: 5-bit even parity, good then bad
        cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        repeat (4) @(negedge clk);
        send(8'h16, 5, 1, 0, 0, 1, 40);
        send(8'h0B, 5, 1, 0, 1, 1, 40);

        // R4: 7-bit odd parity, good then bad
        cfg_len = 2'd2; cfg_par_odd = 1'b1;
        repeat (4) @(negedge clk);
        send(8'h55, 7, 1, 1, 0, 1, 40);
        send(8'h7E, 7, 1, 1, 1, 1, 40);

        // R5: framing error, then one followed directly by a new frame
        cfg_len = 2'd3; cfg_par_en = 1'b0;
        repeat (4) @(negedge clk);
        send(8'h5A, 8, 0, 0, 0, 0, 40);
        a0 = n_acc;
        send(8'h81, 8, 0, 0, 0, 0, 0);
        send(8'h33, 8, 0, 0, 0, 1, 40);
        chk(n_acc == a0 + 2, "R5 frame after framing error", n_acc, a0 + 2);

        // R7: break
        a0 = n_acc; b0 = n_bs;
        rx_in = 1'b0; repeat (16 * 20) @(negedge clk);
        rx_in = 1'b1; repeat (40) @(negedge clk);
        chk(n_acc == a0, "R7 no character on break", n_acc, a0);
        chk(n_bs == b0 + 1 && n_be == 1, "R7 break pulses", n_bs, b0 + 1);

        // R6 / R8: consumer stalls
        out_ready = 1'b0;
        send(8'h11, 8, 0, 0, 0, 1, 20);
        hold_d = out_data;
        repeat (30) @(negedge clk);
        chk(out_valid && out_data == hold_d && out_data == 8'h11, "R8 held while stalled",
            out_data, 8'h11);
        send(8'h22, 8, 0, 0, 0, 1, 20);
        chk(out_valid && out_ovr && out_data == 8'h22, "R6 overrun flagged", out_ovr, 1);
        out_ready = 1'b1;
        repeat (4) @(negedge clk);
        chk(!out_valid, "R6 drained", out_valid, 0);
        send(8'h44, 8, 0, 0, 0, 1, 40);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule